// File: doc/BRIEF.md
# Two-Phase Self-Test Sequencer

This controller steers a self-test session over a chain of three test registers (head, middle, tail) with a combinational block between each neighbouring pair. In the first phase the head register produces pseudo-random patterns and the middle register compacts the response of the first block. In the second phase the pattern source moves one step down the chain: the middle register generates and the tail register compacts the response of the second block. After each generation phase all three registers shift as one scan chain, and the sequencer checks the serial stream that comes back against a reference signature applied at its inputs.

A session starts with a pulse on `start`. The length of each generation phase comes from `pat_len`, which is latched when the start is accepted. Each phase ends with a scan of exactly `SIG_W` bits, compared most significant bit first. The sequencer then raises `done` together with one pass flag per phase. The registers and the logic under test sit outside this block. It drives only their mode codes, their clock enables and their seed strobes.

Top module: `bist_sequencer`

## Requirements
- R1: After reset, all three mode outputs are 2'b00 (normal), and all clock enables, seed strobes, `done`, `pass_a` and `pass_b` are 0.
- R2: In the first generation phase, which lasts `pat_len` cycles, the head register gets mode 2'b01 (pattern generate) and the middle register gets mode 2'b10 (signature compact), both with clock enable 1. The tail register gets 2'b00 with clock enable 0.
- R3: The single cycle right after an accepted start, and the single cycle right after the first scan, are seed cycles. In a seed cycle the two registers of the coming phase show their coming modes with clock enable 0 and seed strobe 1. The third register is in mode 2'b00 with its strobe at 0.
- R4: After each generation phase there are exactly `SIG_W` scan cycles. In these cycles all three registers get mode 2'b11 with clock enable 1 and seed strobe 0.
- R5: In the second generation phase, which lasts `pat_len` cycles, the middle register gets 2'b01 and the tail register gets 2'b10, both enabled. The head register gets 2'b00 and is not enabled.
- R6: In scan cycle k (k = 0 first), `scan_bit` is compared with bit `SIG_W-1-k` of the reference for that phase (`sig_ref_a` for the first phase, `sig_ref_b` for the second). A phase passes only if all `SIG_W` bits match. A single differing bit, or a bit-reversed stream, clears that phase's flag.
- R7: A `pat_len` of zero skips the generation cycles, so the seed cycle is followed directly by the scan.
- R8: `done` rises in the cycle after the last scan bit of the second phase, and the sequencer then returns to idle. `done`, `pass_a` and `pass_b` hold their values until the next accepted start, which clears all three.
- R9: `start` is ignored in every state except idle, including the one-cycle final state.
- R10: Changes on `pat_len` after a start has been accepted do not change the length of either generation phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Session start request, accepted only in idle |
| pat_len | input | CNT_W | Pattern cycles per generation phase |
| sig_ref_a | input | SIG_W | Reference signature for the first block |
| sig_ref_b | input | SIG_W | Reference signature for the second block |
| scan_bit | input | 1 | Serial scan stream returning from the chain |
| hd_mode | output | 2 | Head register mode code |
| md_mode | output | 2 | Middle register mode code |
| tl_mode | output | 2 | Tail register mode code |
| hd_en | output | 1 | Head register clock enable |
| md_en | output | 1 | Middle register clock enable |
| tl_en | output | 1 | Tail register clock enable |
| hd_seed | output | 1 | Head register seed/clear strobe |
| md_seed | output | 1 | Middle register seed/clear strobe |
| tl_seed | output | 1 | Tail register seed/clear strobe |
| done | output | 1 | Session complete, flags valid |
| pass_a | output | 1 | First phase signature matched |
| pass_b | output | 1 | Second phase signature matched |

## Verification
Take the edge that accepts `start` as edge 0, and let N be `pat_len` and W be `SIG_W`. The first seed cycle is period 1. The first generation phase covers periods 2 to N+1 and the first scan covers N+2 to N+W+1. The second seed cycle is period N+W+2, the second generation phase covers N+W+3 to 2N+W+2, and the second scan covers 2N+W+3 to 2N+2W+2. `done` is due in period 2N+2W+3. The mode, enable and strobe outputs decode straight from the state register, so the bench computes the expected output word for each period from this arithmetic and compares it at the falling edge. It drives each scan bit at the falling edge inside its scan period, so the design samples that bit on the next rising edge. It reads the flags in the final period, in the first idle period, and again after several idle cycles.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;

   localparam int NUM_TREGS = 3;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_PRBS   = 2'b01,
      MODE_SIG    = 2'b10,
      MODE_SCAN   = 2'b11
   } treg_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEED1,
      ST_GEN1,
      ST_SCAN1,
      ST_SEED2,
      ST_GEN2,
      ST_SCAN2,
      ST_DONE
   } seq_state_e;

   typedef struct packed {
      treg_mode_e mode;
      logic       clk_en;
      logic       seed;
   } treg_ctrl_t;

endpackage

// File: rtl/bist_seq_counter.sv
module bist_seq_counter #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic [CW-1:0] count,
   output logic          is_zero
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (count != '0)
         count <= count - CW'(1);
   end

   assign is_zero = (count == '0);

   AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !is_zero) |=> (count == $past(count) - CW'(1))); // R4

endmodule

// File: rtl/bist_seq_fsm.sv
module bist_seq_fsm
   import bist_seq_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int SIG_W = 16,
   parameter int CW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] pat_len,
   output seq_state_e       state,
   output logic             accept,
   output logic [CW-1:0]    count,
   output logic             scan_last
);

   seq_state_e       state_nx;
   logic [CNT_W-1:0] len_q;
   logic             ld;
   logic [CW-1:0]    ld_val;
   logic             cnt_zero;

   localparam logic [CW-1:0] SCAN_LOAD = CW'(SIG_W - 1);

   assign accept = (state == ST_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         len_q <= '0;
      end else begin
         state <= state_nx;
         if (accept)
            len_q <= pat_len;
      end
   end

   always_comb begin
      state_nx = state;
      ld       = 1'b0;
      ld_val   = SCAN_LOAD;
      unique case (state)
         ST_IDLE:  if (start) state_nx = ST_SEED1;
         ST_SEED1, ST_SEED2: begin
            ld = 1'b1;
            if (len_q == '0) begin
               state_nx = (state == ST_SEED1) ? ST_SCAN1 : ST_SCAN2;
            end else begin
               ld_val   = CW'(len_q) - CW'(1);
               state_nx = (state == ST_SEED1) ? ST_GEN1 : ST_GEN2;
            end
         end
         ST_GEN1, ST_GEN2: begin
            if (cnt_zero) begin
               ld       = 1'b1;
               state_nx = (state == ST_GEN1) ? ST_SCAN1 : ST_SCAN2;
            end
         end
         ST_SCAN1: if (cnt_zero) state_nx = ST_SEED2;
         ST_SCAN2: if (cnt_zero) state_nx = ST_DONE;
         ST_DONE:  state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   bist_seq_counter #(.CW(CW)) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .count    (count),
      .is_zero  (cnt_zero)
   );

   assign scan_last = ((state == ST_SCAN1) || (state == ST_SCAN2)) && cnt_zero;

   AST_START_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_DONE) |=> (state != ST_IDLE)); // R9
   AST_SEED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEED1 || state == ST_SEED2) |=> !(state == ST_SEED1 || state == ST_SEED2)); // R3
   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE) |=> (state == ST_IDLE)); // R8

endmodule

// File: rtl/bist_seq_decode.sv
module bist_seq_decode
   import bist_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  seq_state_e state,
   output treg_ctrl_t ctrl [NUM_TREGS]
);

   logic in_scan;
   logic in_seed;
   logic in_gen;
   logic phase_b;

   assign in_scan = (state == ST_SCAN1) || (state == ST_SCAN2);
   assign in_seed = (state == ST_SEED1) || (state == ST_SEED2);
   assign in_gen  = (state == ST_GEN1)  || (state == ST_GEN2);
   assign phase_b = (state == ST_SEED2) || (state == ST_GEN2);

   for (genvar gi = 0; gi < NUM_TREGS; gi++) begin : g_treg
      logic is_src;
      logic is_sink;
      assign is_src  = phase_b ? (gi == 1) : (gi == 0);
      assign is_sink = phase_b ? (gi == 2) : (gi == 1);

      always_comb begin
         ctrl[gi] = '{mode: MODE_NORMAL, clk_en: 1'b0, seed: 1'b0};
         if (in_scan) begin
            ctrl[gi].mode   = MODE_SCAN;
            ctrl[gi].clk_en = 1'b1;
         end else if ((in_seed || in_gen) && (is_src || is_sink)) begin
            ctrl[gi].mode   = is_src ? MODE_PRBS : MODE_SIG;
            ctrl[gi].clk_en = in_gen;
            ctrl[gi].seed   = in_seed;
         end
      end
   end

   AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctrl[0].mode == MODE_PRBS, ctrl[1].mode == MODE_PRBS,
                ctrl[2].mode == MODE_PRBS})); // R5
   AST_SEED_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[0].seed || ctrl[1].seed || ctrl[2].seed)
      |-> !(ctrl[0].clk_en || ctrl[1].clk_en || ctrl[2].clk_en)); // R3

endmodule

// File: rtl/bist_seq_compare.sv
module bist_seq_compare #(
   parameter int SIG_W     = 16,
   parameter int CW        = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             scan_valid,
   input  logic             scan_last,
   input  logic             phase_b,
   input  logic [CW-1:0]    idx,
   input  logic [SIG_W-1:0] ref_a,
   input  logic [SIG_W-1:0] ref_b,
   input  logic             scan_bit,
   output logic             pass_a,
   output logic             pass_b
);

   logic [SIG_W-1:0] ref_sel;
   logic             ref_bit;
   logic             miss_now;
   logic             err_q;

   assign ref_sel = phase_b ? ref_b : ref_a;

   if (MSB_FIRST) begin : g_msb_first
      always_comb begin
         ref_bit = 1'b0;
         for (int b = 0; b < SIG_W; b++)
            if (CW'(b) == idx) ref_bit = ref_sel[b];
      end
   end else begin : g_lsb_first
      always_comb begin
         ref_bit = 1'b0;
         for (int b = 0; b < SIG_W; b++)
            if (CW'(SIG_W - 1 - b) == idx) ref_bit = ref_sel[b];
      end
   end

   assign miss_now = scan_valid && (scan_bit != ref_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         pass_a <= 1'b0;
         pass_b <= 1'b0;
      end else if (clear) begin
         err_q  <= 1'b0;
         pass_a <= 1'b0;
         pass_b <= 1'b0;
      end else if (scan_last) begin
         err_q <= 1'b0;
         if (phase_b) pass_b <= !(err_q || miss_now);
         else         pass_a <= !(err_q || miss_now);
      end else if (miss_now) begin
         err_q <= 1'b1;
      end
   end

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      scan_valid |-> (idx < CW'(SIG_W))); // R6
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_last && !clear) |=> $stable({pass_a, pass_b})); // R8

endmodule

// File: rtl/bist_sequencer.sv
module bist_sequencer
   import bist_seq_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int SIG_W     = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] pat_len,
   input  logic [SIG_W-1:0] sig_ref_a,
   input  logic [SIG_W-1:0] sig_ref_b,
   input  logic             scan_bit,
   output logic [1:0]       hd_mode,
   output logic [1:0]       md_mode,
   output logic [1:0]       tl_mode,
   output logic             hd_en,
   output logic             md_en,
   output logic             tl_en,
   output logic             hd_seed,
   output logic             md_seed,
   output logic             tl_seed,
   output logic             done,
   output logic             pass_a,
   output logic             pass_b
);

   localparam int IDX_W = $clog2(SIG_W);
   localparam int CW    = (CNT_W > IDX_W + 1) ? CNT_W : IDX_W + 1;

   if (SIG_W < 2) begin : g_bad_sig_w
      $error("bist_sequencer: SIG_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("bist_sequencer: CNT_W must be at least 1");
   end

   seq_state_e    state;
   logic          accept;
   logic [CW-1:0] count;
   logic          scan_last;
   logic          scan_valid;
   logic          in_phase_b;
   treg_ctrl_t    ctrl [NUM_TREGS];

   bist_seq_fsm #(.CNT_W(CNT_W), .SIG_W(SIG_W), .CW(CW)) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .pat_len   (pat_len),
      .state     (state),
      .accept    (accept),
      .count     (count),
      .scan_last (scan_last)
   );

   bist_seq_decode i_decode (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state),
      .ctrl  (ctrl)
   );

   assign scan_valid = (state == ST_SCAN1) || (state == ST_SCAN2);
   assign in_phase_b = (state == ST_SCAN2);

   bist_seq_compare #(.SIG_W(SIG_W), .CW(CW), .MSB_FIRST(MSB_FIRST)) i_compare (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .scan_valid (scan_valid),
      .scan_last  (scan_last),
      .phase_b    (in_phase_b),
      .idx        (count),
      .ref_a      (sig_ref_a),
      .ref_b      (sig_ref_b),
      .scan_bit   (scan_bit),
      .pass_a     (pass_a),
      .pass_b     (pass_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         done <= 1'b0;
      else if (accept)
         done <= 1'b0;
      else if (scan_last && in_phase_b)
         done <= 1'b1;
   end

   assign hd_mode = ctrl[0].mode;
   assign md_mode = ctrl[1].mode;
   assign tl_mode = ctrl[2].mode;
   assign hd_en   = ctrl[0].clk_en;
   assign md_en   = ctrl[1].clk_en;
   assign tl_en   = ctrl[2].clk_en;
   assign hd_seed = ctrl[0].seed;
   assign md_seed = ctrl[1].seed;
   assign tl_seed = ctrl[2].seed;

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done); // R8
   AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start && state == ST_IDLE) |=> !done); // R8
   AST_SCAN_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (hd_mode == 2'b11) |-> (md_mode == 2'b11 && tl_mode == 2'b11 && hd_en && md_en && tl_en)); // R4

endmodule

// File: tb/test_bist_sequencer.sv
`timescale 1ns/1ps
module test_bist_sequencer;

   localparam int CNT_W = 4;
   localparam int W     = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [CNT_W-1:0] pat_len = '0;
   logic [W-1:0] sig_ref_a = '0;
   logic [W-1:0] sig_ref_b = '0;
   logic         scan_bit = 1'b0;
   logic [1:0]   hd_mode, md_mode, tl_mode;
   logic         hd_en, md_en, tl_en, hd_seed, md_seed, tl_seed;
   logic         done, pass_a, pass_b;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   bist_sequencer #(.CNT_W(CNT_W), .SIG_W(W), .MSB_FIRST(1'b1)) i_bist_sequencer (
      .clk (clk), .rst_n (rst_n), .start (start), .pat_len (pat_len),
      .sig_ref_a (sig_ref_a), .sig_ref_b (sig_ref_b), .scan_bit (scan_bit),
      .hd_mode (hd_mode), .md_mode (md_mode), .tl_mode (tl_mode),
      .hd_en (hd_en), .md_en (md_en), .tl_en (tl_en),
      .hd_seed (hd_seed), .md_seed (md_seed), .tl_seed (tl_seed),
      .done (done), .pass_a (pass_a), .pass_b (pass_b)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [11:0] ctrl_word();
      return {hd_mode, md_mode, tl_mode, hd_en, md_en, tl_en, hd_seed, md_seed, tl_seed};
   endfunction

   // modes: 00 normal, 01 generate, 10 compact, 11 scan
   function automatic logic [11:0] exp_ctrl(input int p, input int n);
      int s1  = n + 2;
      int sd2 = n + W + 2;
      int s2  = 2 * n + W + 3;
      int l   = 2 * n + 2 * W + 3;
      if (p == 1)                  return {2'b01, 2'b10, 2'b00, 3'b000, 3'b110};
      if (p >= 2 && p < s1)        return {2'b01, 2'b10, 2'b00, 3'b110, 3'b000};
      if (p >= s1 && p < sd2)      return {2'b11, 2'b11, 2'b11, 3'b111, 3'b000};
      if (p == sd2)                return {2'b00, 2'b01, 2'b10, 3'b000, 3'b011};
      if (p > sd2 && p < s2)       return {2'b00, 2'b01, 2'b10, 3'b011, 3'b000};
      if (p >= s2 && p < l)        return {2'b11, 2'b11, 2'b11, 3'b111, 3'b000};
      return 12'h000;
   endfunction

   function automatic string tag_of(input int p, input int n, input bit poke);
      if (poke && p > 1) return "R9 R10 timeline";
      if (n == 0)        return "R7 zero length";
      if (p == 1 || p == n + W + 2) return "R3 seed";
      if (p >= 2 && p < n + 2) return "R2 phase one";
      if (p > n + W + 2 && p < 2 * n + W + 3) return "R5 phase two";
      return "R4 scan";
   endfunction

   task automatic run_session(input int n, input logic [W-1:0] ra, input logic [W-1:0] rb,
                              input logic [W-1:0] sa, input logic [W-1:0] sb, input bit poke);
      int l = 2 * n + 2 * W + 3;
      start     = 1'b1;
      pat_len   = CNT_W'(n);
      sig_ref_a = ra;
      sig_ref_b = rb;
      for (int p = 1; p <= l + 1; p++) begin
         @(negedge clk);
         start = 1'b0;
         if (poke && p == 2) begin start = 1'b1; pat_len = ~CNT_W'(n); end
         if (poke && p == l) start = 1'b1;
         if (p >= n + 2 && p < n + W + 2)
            scan_bit = sa[W - 1 - (p - n - 2)];
         else if (p >= 2 * n + W + 3 && p < l)
            scan_bit = sb[W - 1 - (p - 2 * n - W - 3)];
         else
            scan_bit = 1'b0;
         chk(tag_of(p, n, poke), 32'(ctrl_word()), 32'(exp_ctrl(p, n)));
         chk("R8 done timing", 32'(done), 32'(p >= l));
         if (p >= l) begin
            chk("R6 pass_a", 32'(pass_a), 32'(sa == ra));
            chk("R6 pass_b", 32'(pass_b), 32'(sb == rb));
         end
      end
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 hold done", 32'(done), 32'd1);
      chk("R8 hold flags", 32'({pass_a, pass_b}), 32'({sa == ra, sb == rb}));
   endtask

   function automatic logic [W-1:0] rev(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W - 1 - i];
      return r;
   endfunction

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset ctrl", 32'(ctrl_word()), 32'd0);
      chk("R1 reset flags", 32'({done, pass_a, pass_b}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 32'({ctrl_word(), done, pass_a, pass_b}), 32'd0);
      for (int n = 0; n < 5; n++)
         run_session(n, 8'hA5 ^ 8'(n), 8'h3C + 8'(n), 8'hA5 ^ 8'(n), 8'h3C + 8'(n), 1'b0);
      for (int b = 0; b < W; b++)
         run_session(2, 8'h96, 8'h71, 8'h96 ^ (8'h01 << b), 8'h71, 1'b0);
      for (int b = 0; b < W; b++)
         run_session(1, 8'h4E, 8'hD2, 8'h4E, 8'hD2 ^ (8'h01 << b), 1'b0);
      run_session(3, 8'h1D, 8'hB8, rev(8'h1D), rev(8'hB8), 1'b0);
      run_session(2, 8'h5A, 8'hC3, 8'h5A, 8'hC3, 1'b1);
      run_session(0, 8'h0F, 8'hF0, 8'h0E, 8'hF0, 1'b1);
      run_session(15, 8'hE7, 8'h18, 8'hE7, 8'h18, 1'b0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule